// File: doc/BRIEF.md
# Microcoded SPI Transfer Sequencer

This block is a half-duplex SPI master whose bus activity is set by a small program rather than by a fixed transfer length. The host loads a 64-bit program word that holds eight one-byte instructions. The sequencer runs them from the top byte down. The instructions can drive a chip select, shift bytes out of a transmit word, shift bytes into a receive word, copy the transmit word straight into the receive word, and branch back under control of a loop counter.

The host sees six 64-bit registers on a simple single-cycle register port: program, loop count, clock configuration, transmit data, receive data and status. Transmit and receive data move through one-word holding registers with full flags. Back-pressure works like a valid/ready handshake carried by those flags. A shift-out instruction waits with SCK idle until the transmit word is valid, and clears transmit-full in the cycle it takes the word. The host must not write a new transmit word while transmit-full is set. Receive-full stays set until the host reads the word, and a new word that arrives while it is set is lost.

Register offsets on `host_addr`: 0 program, 1 loop count, 2 clock configuration, 3 transmit data (write), 4 receive data (read), 5 status. Other offsets read as zero.

Top module: `spi_seq_top`

## Requirements
- R1: After reset, status reads 64'h0001_0000_0000_0000: only bit 48 (idle) is set, and the state field in bits 55:48 is 8'h01. All `cs_n` lines are high and `sck` is low.
- R2: A write to the program register while the sequencer is idle starts execution at instruction index 0, which is bits 63:56. Each later index is the next lower byte. Opcode 8'h00 returns the sequencer to idle, and so does running past index 7.
- R3: Opcode 8'h1n with 1 <= n <= NCS drives `cs_n[n-1]` low and every other line high. Opcode 8'h10, or any n greater than NCS, drives all lines high. At most one line is ever low.
- R4: Opcode 8'h3n (n from 1 to 8, larger values treated as 8) consumes one transmit word and sends its top n bytes, starting at bits 63:56. Each byte goes most significant bit first in SPI mode 0: MOSI changes while SCK is low, and MISO is sampled on the rising edge. Transmit-full (status bit 59) clears when the word is taken.
- R5: If a shift-out instruction finds transmit-full clear, the sequencer waits in state 8'h04 (status bit 50) with SCK low and does not set transmit underrun. It continues once the host writes a word.
- R6: Opcode 8'h4n shifts in n bytes (n from 1 to 8, larger values treated as 8) while driving MOSI low. The bytes are placed right-aligned in the receive word, with the last byte in bits 7:0 and the upper bytes zero. Receive-full (status bit 63) is set until the host reads offset 4.
- R7: Opcode 8'hEn jumps to index n while the loop count (bits 39:32 of offset 1) is nonzero, and decrements the count on each taken jump. With a count of zero it falls through. A loaded value L therefore runs the loop body L + 1 times and leaves the count at zero.
- R8: Opcode 8'hC0 moves the transmit word into the receive word, setting receive-full and clearing transmit-full. If transmit-full is clear, it sets transmit underrun (status bit 57) and leaves the receive word untouched.
- R9: A transmit-data write while transmit-full is set sets transmit overrun (status bit 58) and is discarded.
- R10: A receive-data read while receive-full is clear sets receive underrun (status bit 61). A completed shift-in that finds receive-full set sets receive overrun (status bit 62) and keeps the older word.
- R11: The SCK period is 2 * (D + 1) system clocks, where D is the divider in bits 63:52 of offset 2. SCK toggles only while a byte is being shifted.
- R12: A write to offset 2 with bits 39:36 = 4'b0101, followed by a write with bits 39:36 = 4'b1010, resets the sequencer, chip selects, loop count, full flags and error flags. Status is then idle-only. The second pattern alone has no effect, and neither pattern changes the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effect only at offset 4) |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 64 | Write data |
| host_rdata | output | 64 | Read data for `host_addr`, combinational |
| sck | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
Shift-out programs use random words, byte counts, chip selects and dividers. They show whether bytes leave in top-down, MSB-first order, whether the right single select is active, and whether the SCK period follows the divider. Shift-in programs use random MISO patterns and lengths from 1 to 8, which separate right alignment from left alignment and catch byte reversal. Directed programs cover counted loops that need several transmit words, a stall with an empty transmit word, copy with full and with empty transmit data, and a program with no stop opcode. Other directed sequences provoke each error flag and check that the soft-reset handshake needs both writes in order.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [7:0] {
    ST_IDLE    = 8'h01,
    ST_FETCH   = 8'h02,
    ST_WAIT_TX = 8'h04,
    ST_SHOUT   = 8'h08,
    ST_SHIN    = 8'h10
  } seq_state_e;

  localparam logic [3:0] OPC_STOP = 4'h0;
  localparam logic [3:0] OPC_CS   = 4'h1;
  localparam logic [3:0] OPC_OUT  = 4'h3;
  localparam logic [3:0] OPC_IN   = 4'h4;
  localparam logic [3:0] OPC_COPY = 4'hC;
  localparam logic [3:0] OPC_BR   = 4'hE;

  localparam logic [2:0] A_PROG = 3'd0;
  localparam logic [2:0] A_LOOP = 3'd1;
  localparam logic [2:0] A_CLK  = 3'd2;
  localparam logic [2:0] A_TX   = 3'd3;
  localparam logic [2:0] A_RX   = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;

  localparam logic [3:0] RST_ARM  = 4'b0101;
  localparam logic [3:0] RST_FIRE = 4'b1010;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_byte
);
  logic             active;
  logic             sck_q;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       tx_sr;
  logic [7:0]       rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sck_q  <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      done   <= 1'b0;
    end else if (soft_rst) begin
      active <= 1'b0;
      sck_q  <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        cnt    <= '0;
        bitn   <= '0;
        sck_q  <= 1'b0;
        tx_sr  <= tx_byte;
      end else if (active) begin
        if (cnt == div) begin
          cnt <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_sr <= {rx_sr[6:0], miso};
          end else begin
            sck_q <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bitn  <= bitn + 3'd1;
              tx_sr <= {tx_sr[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = active & tx_sr[7];
  assign busy    = active;
  assign rx_byte = rx_sr;
endmodule

// File: rtl/spi_data_regs.sv
module spi_data_regs #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              host_tx_wr,
  input  logic [WORD_W-1:0] host_tx_data,
  input  logic              host_rx_rd,
  input  logic              tx_ready,
  input  logic              tx_under_evt,
  input  logic              rx_push,
  input  logic [WORD_W-1:0] rx_word,
  output logic              tx_full,
  output logic [WORD_W-1:0] tx_data,
  output logic              rx_full,
  output logic [WORD_W-1:0] rx_data,
  output logic              tx_und,
  output logic              tx_ovr,
  output logic              rx_und,
  output logic              rx_ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_data <= '0;
      tx_und  <= 1'b0;
      tx_ovr  <= 1'b0;
    end else if (soft_rst) begin
      tx_full <= 1'b0;
      tx_und  <= 1'b0;
      tx_ovr  <= 1'b0;
    end else begin
      if (host_tx_wr) begin
        if (tx_full) tx_ovr <= 1'b1;
        else begin
          tx_data <= host_tx_data;
          tx_full <= 1'b1;
        end
      end
      if (tx_ready && tx_full) tx_full <= 1'b0;
      if (tx_under_evt) tx_und <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_data <= '0;
      rx_und  <= 1'b0;
      rx_ovr  <= 1'b0;
    end else if (soft_rst) begin
      rx_full <= 1'b0;
      rx_und  <= 1'b0;
      rx_ovr  <= 1'b0;
    end else begin
      if (host_rx_rd) begin
        if (!rx_full) rx_und <= 1'b1;
        else rx_full <= 1'b0;
      end
      if (rx_push) begin
        if (rx_full && !host_rx_rd) rx_ovr <= 1'b1;
        else begin
          rx_data <= rx_word;
          rx_full <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_seq_core.sv
module spi_seq_core
  import spi_seq_pkg::*;
#(
  parameter int NCS    = 4,
  parameter int WORD_W = 64,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              start,
  input  logic [WORD_W-1:0] prog,
  input  logic              loop_wr,
  input  logic [LOOP_W-1:0] loop_wdata,
  output logic [LOOP_W-1:0] loop_cnt,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              tx_under,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  output logic              sh_start,
  output logic [7:0]        sh_byte,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  output logic [NCS-1:0]    cs_n,
  output seq_state_e        state
);
  localparam int NINS  = WORD_W / 8;
  localparam int IDX_W = $clog2(NINS);
  localparam int CNT_W = $clog2(NINS + 1);

  logic [WORD_W-1:0] prog_q;
  logic [IDX_W-1:0]  pc;
  logic [CNT_W-1:0]  left;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-9:0] acc;
  logic [7:0]        op;
  logic [3:0]        opc;
  logic [3:0]        arg;
  logic [CNT_W-1:0]  nbytes;
  logic              last_idx;
  logic [NCS-1:0]    cs_dec;
  logic              is_copy;

  assign op       = prog_q[(NINS-1-int'(pc))*8 +: 8];
  assign opc      = op[7:4];
  assign arg      = op[3:0];
  assign nbytes   = (arg > 4'(NINS)) ? CNT_W'(NINS) : CNT_W'(arg);
  assign last_idx = (pc == IDX_W'(NINS-1));
  assign is_copy  = (state == ST_FETCH) && (op == {OPC_COPY, 4'h0});

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_dec[i] = (arg != 4'(i + 1));
  end

  assign tx_ready = ((state == ST_WAIT_TX) && tx_valid) || (is_copy && tx_valid);
  assign tx_under = is_copy && !tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      prog_q   <= '0;
      pc       <= '0;
      left     <= '0;
      word_q   <= '0;
      acc      <= '0;
      loop_cnt <= '0;
      cs_n     <= '1;
      sh_start <= 1'b0;
      sh_byte  <= '0;
      rx_push  <= 1'b0;
      rx_word  <= '0;
    end else if (soft_rst) begin
      state    <= ST_IDLE;
      pc       <= '0;
      left     <= '0;
      loop_cnt <= '0;
      cs_n     <= '1;
      sh_start <= 1'b0;
      rx_push  <= 1'b0;
    end else begin
      sh_start <= 1'b0;
      rx_push  <= 1'b0;
      if (loop_wr) loop_cnt <= loop_wdata;
      case (state)
        ST_IDLE: begin
          if (start) begin
            prog_q <= prog;
            pc     <= '0;
            state  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          pc    <= pc + 1'b1;
          state <= last_idx ? ST_IDLE : ST_FETCH;
          case (opc)
            OPC_STOP: begin
              if (arg == 4'h0) state <= ST_IDLE;
            end
            OPC_CS: begin
              cs_n <= cs_dec;
            end
            OPC_OUT: begin
              if (nbytes != '0) begin
                pc    <= pc;
                left  <= nbytes;
                state <= ST_WAIT_TX;
              end
            end
            OPC_IN: begin
              if (nbytes != '0) begin
                pc       <= pc;
                left     <= nbytes;
                acc      <= '0;
                sh_start <= 1'b1;
                sh_byte  <= 8'h00;
                state    <= ST_SHIN;
              end
            end
            OPC_COPY: begin
              if (arg == 4'h0 && tx_valid) begin
                rx_push <= 1'b1;
                rx_word <= tx_data;
              end
            end
            OPC_BR: begin
              if (loop_cnt != '0) begin
                loop_cnt <= loop_cnt - 1'b1;
                if (int'(arg) >= NINS) state <= ST_IDLE;
                else begin
                  pc    <= arg[IDX_W-1:0];
                  state <= ST_FETCH;
                end
              end
            end
            default: ;
          endcase
        end
        ST_WAIT_TX: begin
          if (tx_valid) begin
            sh_start <= 1'b1;
            sh_byte  <= tx_data[WORD_W-1 -: 8];
            word_q   <= {tx_data[WORD_W-9:0], 8'h00};
            state    <= ST_SHOUT;
          end
        end
        ST_SHOUT: begin
          if (sh_done) begin
            if (left == CNT_W'(1)) begin
              pc    <= pc + 1'b1;
              state <= last_idx ? ST_IDLE : ST_FETCH;
            end else begin
              left     <= left - 1'b1;
              sh_start <= 1'b1;
              sh_byte  <= word_q[WORD_W-1 -: 8];
              word_q   <= {word_q[WORD_W-9:0], 8'h00};
            end
          end
        end
        ST_SHIN: begin
          if (sh_done) begin
            acc <= {acc[WORD_W-17:0], sh_rx};
            if (left == CNT_W'(1)) begin
              rx_push <= 1'b1;
              rx_word <= {acc, sh_rx};
              pc      <= pc + 1'b1;
              state   <= last_idx ? ST_IDLE : ST_FETCH;
            end else begin
              left     <= left - 1'b1;
              sh_start <= 1'b1;
              sh_byte  <= 8'h00;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_seq_top.sv
module spi_seq_top
  import spi_seq_pkg::*;
#(
  parameter int NCS       = 4,
  parameter int DIV_W     = 12,
  parameter int LOOP_W    = 8,
  parameter int DIV_RESET = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [2:0]     host_addr,
  input  logic [63:0]    host_wdata,
  output logic [63:0]    host_rdata,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  localparam int WORD_W   = 64;
  localparam int DIV_LSB  = WORD_W - DIV_W;
  localparam int LOOP_LSB = 32;

  logic [DIV_W-1:0]  div_q;
  logic              armed;
  logic              soft_rst;
  logic [3:0]        rst_code;
  logic              tx_wr, rx_rd, seq_wr, loop_wr, clk_wr;
  logic              tx_full, rx_full, tx_und, tx_ovr, rx_und, rx_ovr;
  logic [WORD_W-1:0] tx_data, rx_data, rx_word;
  logic              tx_ready, tx_under, rx_push;
  logic              sh_start, sh_done, sh_busy;
  logic [7:0]        sh_byte, sh_rx;
  logic [LOOP_W-1:0] loop_cnt;
  seq_state_e        seq_state;
  logic [WORD_W-1:0] status_w;

  assign seq_wr   = host_wr && host_addr == A_PROG;
  assign loop_wr  = host_wr && host_addr == A_LOOP;
  assign clk_wr   = host_wr && host_addr == A_CLK;
  assign tx_wr    = host_wr && host_addr == A_TX;
  assign rx_rd    = host_rd && host_addr == A_RX;
  assign rst_code = host_wdata[39:36];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= DIV_W'(DIV_RESET);
      armed    <= 1'b0;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= 1'b0;
      if (clk_wr) begin
        armed <= 1'b0;
        if (rst_code == RST_ARM) armed <= 1'b1;
        else if (rst_code == RST_FIRE) soft_rst <= armed;
        else div_q <= host_wdata[WORD_W-1:DIV_LSB];
      end
    end
  end

  spi_data_regs #(.WORD_W(WORD_W)) u_data (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .host_tx_wr(tx_wr), .host_tx_data(host_wdata), .host_rx_rd(rx_rd),
    .tx_ready(tx_ready), .tx_under_evt(tx_under),
    .rx_push(rx_push), .rx_word(rx_word),
    .tx_full(tx_full), .tx_data(tx_data), .rx_full(rx_full), .rx_data(rx_data),
    .tx_und(tx_und), .tx_ovr(tx_ovr), .rx_und(rx_und), .rx_ovr(rx_ovr)
  );

  spi_seq_core #(.NCS(NCS), .WORD_W(WORD_W), .LOOP_W(LOOP_W)) u_core (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .start(seq_wr), .prog(host_wdata),
    .loop_wr(loop_wr), .loop_wdata(host_wdata[LOOP_LSB +: LOOP_W]), .loop_cnt(loop_cnt),
    .tx_valid(tx_full), .tx_data(tx_data), .tx_ready(tx_ready), .tx_under(tx_under),
    .rx_push(rx_push), .rx_word(rx_word),
    .sh_start(sh_start), .sh_byte(sh_byte), .sh_done(sh_done), .sh_rx(sh_rx),
    .cs_n(cs_n), .state(seq_state)
  );

  spi_byte_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .div(div_q),
    .start(sh_start), .tx_byte(sh_byte), .miso(miso),
    .sck(sck), .mosi(mosi), .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx)
  );

  assign status_w = {rx_full, rx_ovr, rx_und, 1'b0, tx_full, tx_ovr, tx_und, 1'b0,
                     seq_state, 48'h0};

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_PROG: host_rdata = u_core.prog_q;
      A_LOOP: host_rdata[LOOP_LSB +: LOOP_W] = loop_cnt;
      A_CLK:  host_rdata[WORD_W-1:DIV_LSB] = div_q;
      A_RX:   host_rdata = rx_data;
      A_STAT: host_rdata = status_w;
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk
  import spi_seq_pkg::*;
#(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] cs_n,
  input logic           sck,
  input seq_state_e     state,
  input logic           soft_rst,
  input logic [63:0]    status,
  input logic           tx_wr,
  input logic           tx_full,
  input logic           rx_rd,
  input logic           rx_full,
  input logic           sh_busy
);
  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  // R5
  stall_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_TX) |-> !sck);
  // R11
  sck_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) sck |-> sh_busy);
  // R12
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status == 64'h0001_0000_0000_0000));
  // R9
  tx_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full && !soft_rst) |=> status[58]);
  // R10
  rx_und_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_full && !soft_rst) |=> status[61]);
endmodule

bind spi_seq_top spi_seq_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .state(seq_state),
  .soft_rst(soft_rst), .status(status_w), .tx_wr(tx_wr), .tx_full(tx_full),
  .rx_rd(rx_rd), .rx_full(rx_full), .sh_busy(sh_busy)
);

// File: tb/tb_spi_seq_top.sv
module tb_spi_seq_top;
  localparam int NCS = 4;
  localparam logic [63:0] IDLE_ST = 64'h0001_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic [63:0] host_wdata = '0, host_rdata;
  logic sck, mosi, miso;
  logic [NCS-1:0] cs_n;

  spi_seq_top #(.NCS(NCS)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int unsigned cyc = 0, last_rise = 0, period = 0;
  int unsigned rise_cnt = 0, base = 0;
  logic [63:0] mosi_sr = '0;
  logic [63:0] miso_pat = '0;
  logic [NCS-1:0] last_cs = '1;
  logic [5:0] bidx;

  assign bidx = 6'(rise_cnt - base);
  assign miso = miso_pat[~bidx];

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge sck) begin
    rise_cnt  <= rise_cnt + 1;
    mosi_sr   <= {mosi_sr[62:0], mosi};
    last_cs   <= cs_n;
    period    <= cyc - last_rise;
    last_rise <= cyc;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [63:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd5, s);
      if (s[48]) break;
    end
  endtask

  task automatic wait_tx_empty();
    logic [63:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd5, s);
      if (!s[59]) break;
    end
  endtask

  function automatic logic [63:0] top_bytes(input logic [63:0] w, input int n);
    return (n >= 8) ? w : (w >> (64 - 8 * n));
  endfunction

  function automatic logic [63:0] low_mask(input int n);
    return (n >= 8) ? '1 : ((64'h1 << (8 * n)) - 64'h1);
  endfunction

  task automatic soft_reset();
    wr(3'd2, 64'h0000_0050_0000_0000);
    wr(3'd2, 64'h0000_00A0_0000_0000);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    logic [63:0] s, d, w, pat;
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd5, s);
    chk(s == IDLE_ST, "R1 status after reset", s, IDLE_ST);
    chk(cs_n == '1 && sck == 1'b0, "R1 pins after reset", {cs_n, sck}, {4'hF, 1'b0});

    // R4 R3 R11 random shift-out programs
    for (int t = 0; t < 6; t++) begin
      int n, c, dv;
      int unsigned r0;
      n  = 1 + int'($urandom_range(7));
      c  = 1 + int'($urandom_range(NCS - 1));
      dv = int'($urandom_range(3));
      w  = {$urandom, $urandom};
      wr(3'd2, 64'(dv) << 52);
      wr(3'd3, w);
      r0 = rise_cnt;
      wr(3'd0, {4'h1, 4'(c), 4'h3, 4'(n), 8'h10, 40'h0});
      wait_idle();
      chk((mosi_sr & low_mask(n)) == top_bytes(w, n), "R4 shift-out bytes", mosi_sr & low_mask(n), top_bytes(w, n));
      chk(rise_cnt - r0 == 32'(8 * n), "R4 sck edge count", 64'(rise_cnt - r0), 64'(8 * n));
      chk(last_cs == ~(4'(1) << (c - 1)), "R3 select active during shift", 64'(last_cs), 64'(~(4'(1) << (c - 1))));
      chk(cs_n == '1, "R3 release by 0x10", 64'(cs_n), 64'hF);
      chk(period == 32'(2 * (dv + 1)), "R11 sck period", 64'(period), 64'(2 * (dv + 1)));
      rd(3'd5, s);
      chk(s == IDLE_ST, "R4 tx-full cleared, idle", s, IDLE_ST);
    end
    wr(3'd2, 64'h0);

    // R6 R2 random shift-in programs
    for (int t = 0; t < 6; t++) begin
      int n;
      n = 1 + int'($urandom_range(7));
      pat = {$urandom, $urandom};
      miso_pat = pat;
      base = rise_cnt;
      wr(3'd0, {8'h12, 4'h4, 4'(n), 8'h10, 8'h00, 32'hFFFF_FFFF});
      wait_idle();
      rd(3'd5, s);
      chk(s[63], "R6 rx-full set after shift-in", 64'(s[63]), 64'd1);
      rd(3'd4, d);
      chk(d == top_bytes(pat, n), "R6 right-aligned receive word", d, top_bytes(pat, n));
      rd(3'd5, s);
      chk(s == IDLE_ST, "R2 stop halts, read clears rx-full", s, IDLE_ST);
    end

    // R7 counted loop: two bytes per pass
    for (int t = 0; t < 3; t++) begin
      int L;
      logic [63:0] expv, lc;
      int unsigned r0;
      L = t + 1;
      expv = '0;
      wr(3'd1, 64'(L) << 32);
      r0 = rise_cnt;
      w = {$urandom, $urandom};
      expv = {expv[47:0], w[63:48]};
      wr(3'd3, w);
      wr(3'd0, {8'h11, 8'h32, 8'hE1, 8'h10, 32'h0});
      for (int k = 0; k < L; k++) begin
        wait_tx_empty();
        w = {$urandom, $urandom};
        expv = {expv[47:0], w[63:48]};
        wr(3'd3, w);
      end
      wait_idle();
      chk((mosi_sr & low_mask(2 * (L + 1))) == expv, "R7 loop data", mosi_sr & low_mask(2 * (L + 1)), expv);
      chk(rise_cnt - r0 == 32'(16 * (L + 1)), "R7 loop pass count", 64'(rise_cnt - r0), 64'(16 * (L + 1)));
      rd(3'd1, lc);
      chk(lc == 64'h0, "R7 count left at zero", lc, 64'h0);
    end

    // R5 stall with empty transmit word
    begin
      int unsigned r0;
      r0 = rise_cnt;
      wr(3'd0, {8'h11, 8'h31, 8'h10, 40'h0});
      repeat (60) @(posedge clk);
      rd(3'd5, s);
      chk(s == 64'h0004_0000_0000_0000, "R5 waiting state, no underrun", s, 64'h0004_0000_0000_0000);
      chk(rise_cnt == r0, "R5 sck idle while waiting", 64'(rise_cnt), 64'(r0));
      wr(3'd3, 64'h5A00_0000_0000_0000);
      wait_idle();
      chk(mosi_sr[7:0] == 8'h5A, "R5 resumes after write", 64'(mosi_sr[7:0]), 64'h5A);
    end

    // R9 overrun keeps first word
    wr(3'd3, 64'hC300_0000_0000_0000);
    wr(3'd3, 64'h3C00_0000_0000_0000);
    rd(3'd5, s);
    chk(s[58] && s[59], "R9 overrun flag", {s[58], s[59]}, 2'b11);
    wr(3'd0, {8'h31, 56'h0});
    wait_idle();
    chk(mosi_sr[7:0] == 8'hC3, "R9 second write discarded", 64'(mosi_sr[7:0]), 64'hC3);

    // R12 fire pattern alone is ignored
    wr(3'd2, 64'h0000_00A0_0000_0000);
    repeat (2) @(posedge clk);
    rd(3'd5, s);
    chk(s[58], "R12 lone fire ignored", 64'(s[58]), 64'd1);
    soft_reset();
    rd(3'd5, s);
    chk(s == IDLE_ST, "R12 soft reset clears flags", s, IDLE_ST);
    rd(3'd2, d);
    chk(d == 64'h0, "R12 divider untouched", d, 64'h0);

    // R8 copy with full and empty transmit word
    w = {$urandom, $urandom};
    wr(3'd3, w);
    wr(3'd0, {8'hC0, 56'h0});
    wait_idle();
    rd(3'd5, s);
    chk(s == (IDLE_ST | 64'h8000_0000_0000_0000), "R8 copy sets rx-full, clears tx-full", s, IDLE_ST | 64'h8000_0000_0000_0000);
    rd(3'd4, d);
    chk(d == w, "R8 copied word", d, w);
    wr(3'd0, {8'hC0, 56'h0});
    wait_idle();
    rd(3'd5, s);
    chk(s == (IDLE_ST | 64'h0200_0000_0000_0000), "R8 copy when empty underruns", s, IDLE_ST | 64'h0200_0000_0000_0000);

    // R10 receive underrun and overrun
    soft_reset();
    rd(3'd4, d);
    rd(3'd5, s);
    chk(s[61] && !s[63], "R10 rx underrun", {s[61], s[63]}, 2'b10);
    soft_reset();
    miso_pat = 64'hA5C3_0000_0000_0000;
    base = rise_cnt;
    wr(3'd0, {8'h11, 8'h41, 8'h41, 8'h10, 32'h0});
    wait_idle();
    rd(3'd5, s);
    chk(s[62] && s[63], "R10 rx overrun", {s[62], s[63]}, 2'b11);
    rd(3'd4, d);
    chk(d == 64'hA5, "R10 older word kept", d, 64'hA5);

    // R2 no stop: runs past index 7
    soft_reset();
    wr(3'd0, 64'h1110_1210_1310_1410);
    repeat (30) @(posedge clk);
    rd(3'd5, s);
    chk(s == IDLE_ST && cs_n == '1, "R2 past last index goes idle", s, IDLE_ST);
    // R3 out-of-range select releases all
    wr(3'd0, {8'h12, 8'h17, 48'h0});
    wait_idle();
    chk(cs_n == '1, "R3 select above range releases", 64'(cs_n), 64'hF);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule